// File: doc/BRIEF.md
# UART Receive Byte Buffer with Status

This block holds received bytes between a UART deserializer and the register interface that software reads. Bytes arrive on a write strobe with their parity and framing flags. A break indication arrives on its own pin. The reader takes bytes through a holding-register read strobe. Two storage modes share that one read port. In queued mode the block is a circular buffer of `DEPTH` bytes (16 by default). In single-register mode it keeps only the most recently received byte.

Besides the data, the block reports a status word and a data-ready flag. The status word carries the queued byte count, a full flag and a sticky error-source flag. A separate error word records overrun, parity, framing and break events and clears when it is read. A two-bit control word selects the mode and offers a receive-buffer flush. The flush bit never reads back as set. Baud timing, parity calculation and address decoding belong to the neighbouring blocks.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is empty. The block is in single-register mode, and `ctrlRd`, `statusWord`, `errWord`, `dataReady`, `errIrq` and `rdData` are all zero.
- R2: A write of `ctrlWdata[0]` selects queued mode (1) or single-register mode (0), and `ctrlRd[0]` reads it back. A write with `ctrlWdata[1]`=1 empties the queue in that cycle. `ctrlRd[1]` always reads 0.
- R3: In queued mode, bytes are read out in arrival order. `statusWord[7:0]` gives the number of queued bytes and `statusWord[8]` is the full flag. When the queue is full, the count field reads 0.
- R4: In queued mode, a byte that arrives while the queue is full, in the same cycle as a read, is stored. The occupancy stays at full and the order is kept.
- R5: In queued mode, a byte that arrives at a full queue with no read in that cycle is dropped. It sets `errWord[0]` (overrun) and the error source `errIrq` (mirrored in `statusWord[9]`).
- R6: In queued mode, a read of an empty queue returns 0x00 and sets the error source.
- R7: In queued mode, `dataReady` is 1 exactly while at least one byte is queued. A read that takes the last byte clears it.
- R8: In single-register mode, each arriving byte replaces the held byte and sets `dataReady`. An arrival while `dataReady` is still set also sets `errWord[0]`. Every read returns the held byte and clears `dataReady`. A read with nothing new returns the old byte and raises no error.
- R9: A `breakIn` pulse stores a 0x00 byte and sets `errWord[3]`. An arriving byte's parity flag sets `errWord[1]` and its framing flag sets `errWord[2]`.
- R10: An `errRd` pulse clears `errWord` in the following cycle. An event in the same cycle as the clear is kept.
- R11: An `errAck` pulse clears the error source `errIrq` and `statusWord[9]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 2 | Control data: bit 0 queued mode, bit 1 flush |
| ctrlRd | output | 2 | Control read-back (bit 1 always 0) |
| wrValid | input | 1 | Received byte strobe from the deserializer |
| wrData | input | 8 | Received byte |
| wrParityErr | input | 1 | Parity error flag of the received byte |
| wrFrameErr | input | 1 | Framing error flag of the received byte |
| breakIn | input | 1 | Break detected pulse |
| rdStb | input | 1 | Holding-register read strobe |
| rdData | output | 8 | Holding-register read data |
| dataReady | output | 1 | Received data available |
| statusWord | output | 10 | {error source, full, count[7:0]} |
| errWord | output | 4 | {break, frame, parity, overrun}, clear on read |
| errRd | input | 1 | Error word read strobe |
| errAck | input | 1 | Error source clear strobe |
| errIrq | output | 1 | Error source pending |

## Verification
A corrupted pointer shows on the very next read. The scoreboard predicts the byte order, so a wrong byte or a zero from a queue that should hold data fails that read. A wrong occupancy shows in the same cycle in the count field, the full flag and `dataReady`. It also shows at the boundaries: an overrun flag that appears too early or too late, or a simultaneous read and write at full that loses a byte. Error-word and error-source faults show one cycle after the triggering strobe, because those registers are observed right after each event and right after each clear.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       flush;
    logic       holdLoad;
    logic [7:0] inByte;
  } rxStb_t;
endpackage

// File: rtl/uart_rxbuf_dp.sv
module uart_rxbuf_dp
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStb_t           stb,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic [7:0]       headByte,
  output logic [7:0]       holdByte
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2  = (DEPTH == (1 << PTR_W));

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrNxt, rdPtrNxt;

  generate
    if (POW2) begin : g_wrapNatural
      assign wrPtrNxt = wrPtr + 1'b1;
      assign rdPtrNxt = rdPtr + 1'b1;
    end else begin : g_wrapCompare
      assign wrPtrNxt = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrNxt = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= stb.inByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtrNxt;
      if (stb.pop)  rdPtr <= rdPtrNxt;
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdByte <= 8'h00;
    else if (stb.holdLoad) holdByte <= stb.inByte;
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headByte = mem[rdPtr];
endmodule

// File: rtl/uart_rxbuf_ctrl.sv
module uart_rxbuf_ctrl
  import uart_rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [1:0] ctrlWdata,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrParityErr,
  input  logic       wrFrameErr,
  input  logic       breakIn,
  input  logic       rdStb,
  input  logic       errRd,
  input  logic       errAck,
  input  logic       full,
  input  logic       empty,
  output rxStb_t     stb,
  output logic       fifoEn,
  output logic       dataReady,
  output logic [3:0] errWord,
  output logic       errIrq
);
  logic holdReady;
  logic flush, inValid, popOk, overrunEv, underEv;

  always_comb begin
    flush        = ctrlWe & ctrlWdata[1];
    inValid      = breakIn | wrValid;
    popOk        = fifoEn & rdStb & ~empty & ~flush;
    stb.flush    = flush;
    stb.pop      = popOk;
    stb.push     = fifoEn & inValid & ~flush & (~full | popOk);
    stb.holdLoad = ~fifoEn & inValid;
    stb.inByte   = breakIn ? 8'h00 : wrData;
    overrunEv    = inValid & (fifoEn ? (full & ~popOk & ~flush)
                                     : (holdReady & ~rdStb));
    underEv      = fifoEn & rdStb & empty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn    <= 1'b0;
      holdReady <= 1'b0;
      errWord   <= '0;
      errIrq    <= 1'b0;
    end else begin
      if (ctrlWe) fifoEn <= ctrlWdata[0];
      if (stb.holdLoad)           holdReady <= 1'b1;
      else if (~fifoEn & rdStb)   holdReady <= 1'b0;
      errWord <= (errRd ? 4'h0 : errWord) |
                 {breakIn, wrValid & wrFrameErr, wrValid & wrParityErr, overrunEv};
      errIrq  <= (errAck ? 1'b0 : errIrq) | overrunEv | underEv;
    end
  end

  assign dataReady = fifoEn ? ~empty : holdReady;
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [1:0] ctrlWdata,
  output logic [1:0] ctrlRd,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrParityErr,
  input  logic       wrFrameErr,
  input  logic       breakIn,
  input  logic       rdStb,
  output logic [7:0] rdData,
  output logic       dataReady,
  output logic [9:0] statusWord,
  output logic [3:0] errWord,
  input  logic       errRd,
  input  logic       errAck,
  output logic       errIrq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxStb_t           stb;
  logic [CNT_W-1:0] fifoCount;
  logic             full, empty, fifoEn;
  logic [7:0]       headByte, holdByte;

  uart_rxbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .wrValid(wrValid), .wrData(wrData), .wrParityErr(wrParityErr),
    .wrFrameErr(wrFrameErr), .breakIn(breakIn), .rdStb(rdStb),
    .errRd(errRd), .errAck(errAck), .full(full), .empty(empty),
    .stb(stb), .fifoEn(fifoEn), .dataReady(dataReady),
    .errWord(errWord), .errIrq(errIrq)
  );

  uart_rxbuf_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .count(fifoCount), .full(full),
    .empty(empty), .headByte(headByte), .holdByte(holdByte)
  );

  assign ctrlRd     = {1'b0, fifoEn};
  assign rdData     = fifoEn ? (empty ? 8'h00 : headByte) : holdByte;
  assign statusWord = {errIrq, full, full ? 8'h00 : 8'(fifoCount)};
endmodule

// File: rtl/uart_rxbuf_chk.sv
module uart_rxbuf_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWe,
  input logic [1:0]       ctrlWdata,
  input logic [1:0]       ctrlRd,
  input logic             wrValid,
  input logic             breakIn,
  input logic             rdStb,
  input logic [7:0]       rdData,
  input logic             dataReady,
  input logic [9:0]       statusWord,
  input logic [3:0]       errWord,
  input logic             errRd,
  input logic             errIrq,
  input logic [CNT_W-1:0] fifoCount
);
  logic flushNow;
  assign flushNow = ctrlWe & ctrlWdata[1];

  p_underflow_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd[0] && rdStb && !dataReady |-> rdData == 8'h00);

  p_overrun_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd[0] && statusWord[8] && wrValid && !rdStb && !breakIn && !flushNow
    |=> errWord[0] && errIrq);

  p_full_pushpop_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd[0] && statusWord[8] && wrValid && rdStb && !flushNow
    |=> statusWord[8]);

  p_push_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd[0] && wrValid && !rdStb && !statusWord[8] && !flushNow
    |=> fifoCount == $past(fifoCount) + 1'b1);

  p_flush_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> statusWord[8:0] == 9'h000 && ctrlRd[1] == 1'b0);

  p_break_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    breakIn |=> errWord[3]);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    errRd && !breakIn && !wrValid && !rdStb |=> errWord == 4'h0);
endmodule

bind uart_rx_buffer uart_rxbuf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .ctrlRd(ctrlRd), .wrValid(wrValid), .breakIn(breakIn), .rdStb(rdStb),
  .rdData(rdData), .dataReady(dataReady), .statusWord(statusWord),
  .errWord(errWord), .errRd(errRd), .errIrq(errIrq), .fifoCount(fifoCount)
);

// File: tb/tb_uart_rx_buffer.sv
module tb_uart_rx_buffer;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [1:0] ctrlWdata = '0;
  logic [1:0] ctrlRd;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrParityErr = 1'b0;
  logic       wrFrameErr = 1'b0;
  logic       breakIn = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] rdData;
  logic       dataReady;
  logic [9:0] statusWord;
  logic [3:0] errWord;
  logic       errRd = 1'b0;
  logic       errAck = 1'b0;
  logic       errIrq;

  int nChk = 0;
  int nErr = 0;
  bit mFifo = 1'b0;
  logic [7:0] mHold = 8'h00;
  logic [7:0] mQ[$];
  logic [7:0] scoreQ[$];
  string curReq = "R3";

  always #10 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // Monitor: every read strobe compares rdData with the scoreboard head
  always @(negedge clk) begin
    if (rstN && rdStb) begin
      if (scoreQ.size() == 0) begin
        chk(curReq, 32'(rdData), 32'hDEAD);
      end else begin
        logic [7:0] e;
        e = scoreQ.pop_front();
        chk(curReq, 32'(rdData), 32'(e));
      end
    end
  end

  task automatic ctrlWrite(input logic [1:0] v);
    ctrlWe = 1'b1; ctrlWdata = v;
    mFifo = v[0];
    if (v[1]) mQ.delete();
    tick();
    ctrlWe = 1'b0; ctrlWdata = '0;
  endtask

  task automatic pushByte(input logic [7:0] b, input logic p = 1'b0, input logic f = 1'b0);
    wrValid = 1'b1; wrData = b; wrParityErr = p; wrFrameErr = f;
    if (mFifo) begin
      if (mQ.size() < DEPTH) mQ.push_back(b);
    end else mHold = b;
    tick();
    wrValid = 1'b0; wrParityErr = 1'b0; wrFrameErr = 1'b0;
  endtask

  task automatic doRead();
    if (mFifo) scoreQ.push_back(mQ.size() != 0 ? mQ.pop_front() : 8'h00);
    else scoreQ.push_back(mHold);
    rdStb = 1'b1;
    tick();
    rdStb = 1'b0;
  endtask

  task automatic pushPop(input logic [7:0] b);
    scoreQ.push_back(mQ.pop_front());
    mQ.push_back(b);
    rdStb = 1'b1; wrValid = 1'b1; wrData = b;
    tick();
    rdStb = 1'b0; wrValid = 1'b0;
  endtask

  task automatic doBreak();
    breakIn = 1'b1;
    if (mFifo && mQ.size() < DEPTH) mQ.push_back(8'h00);
    tick();
    breakIn = 1'b0;
  endtask

  task automatic readErr(input string req, input logic [3:0] exp);
    chk(req, 32'(errWord), 32'(exp));
    errRd = 1'b1;
    tick();
    errRd = 1'b0;
  endtask

  task automatic ack();
    errAck = 1'b1;
    tick();
    errAck = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1", 32'(ctrlRd), 0);
    chk("R1", 32'(statusWord), 0);
    chk("R1", 32'(errWord), 0);
    chk("R1", 32'(dataReady), 0);
    chk("R1", 32'(errIrq), 0);
    chk("R1", 32'(rdData), 0);

    // R2 queued mode select
    ctrlWrite(2'b01);
    chk("R2", 32'(ctrlRd), 1);

    // R3 / R7 basic order, count, ready
    curReq = "R3";
    for (int i = 0; i < 5; i++) pushByte(8'h10 + 8'(i));
    chk("R3", 32'(statusWord[8:0]), 5);
    chk("R7", 32'(dataReady), 1);
    for (int i = 0; i < 4; i++) doRead();
    chk("R7", 32'(dataReady), 1);
    doRead();
    chk("R7", 32'(dataReady), 0);
    chk("R3", 32'(statusWord[8:0]), 0);

    // R3 full: count field zero, full flag set
    for (int i = 0; i < DEPTH; i++) pushByte(8'h40 + 8'(i));
    chk("R3", 32'(statusWord[8:0]), 32'h100);
    chk("R5", 32'(errWord), 0);

    // R5 overflow drops the byte
    pushByte(8'hEE);
    chk("R5", 32'(errWord[0]), 1);
    chk("R5", 32'(statusWord[9]), 1);
    chk("R5", 32'(errIrq), 1);

    // R4 simultaneous push and pop at full
    curReq = "R4";
    pushPop(8'h77);
    chk("R4", 32'(statusWord[8:0]), 32'h100);

    // R11 acknowledge
    ack();
    chk("R11", 32'(statusWord[9]), 0);
    chk("R11", 32'(errIrq), 0);

    // R10 clear on read
    readErr("R10", 4'b0001);
    chk("R10", 32'(errWord), 0);

    // R4 order after the wrap, then R6 underflow
    for (int i = 0; i < DEPTH; i++) doRead();
    chk("R4", 32'(statusWord[8:0]), 0);
    curReq = "R6";
    doRead();
    chk("R6", 32'(statusWord[9]), 1);
    ack();

    // R9 break inserts zero byte
    curReq = "R9";
    doBreak();
    chk("R9", 32'(statusWord[7:0]), 1);
    chk("R9", 32'(errWord), 4'b1000);
    doRead();
    chk("R9", 32'(statusWord[9]), 0);
    readErr("R9", 4'b1000);

    pushByte(8'h5A, 1'b1, 1'b0);
    readErr("R9", 4'b0010);
    pushByte(8'h5B, 1'b0, 1'b1);
    readErr("R9", 4'b0100);
    doRead();
    doRead();

    // R10 event in the clearing cycle is kept
    errRd = 1'b1; breakIn = 1'b1; mQ.push_back(8'h00);
    tick();
    errRd = 1'b0; breakIn = 1'b0;
    chk("R10", 32'(errWord), 4'b1000);
    curReq = "R10";
    doRead();
    readErr("R10", 4'b1000);

    // R2 flush
    for (int i = 0; i < 3; i++) pushByte(8'h30 + 8'(i));
    chk("R2", 32'(statusWord[7:0]), 3);
    ctrlWrite(2'b11);
    chk("R2", 32'(statusWord[8:0]), 0);
    chk("R2", 32'(dataReady), 0);
    chk("R2", 32'(ctrlRd), 1);

    // R8 single-register mode
    curReq = "R8";
    ctrlWrite(2'b00);
    chk("R8", 32'(ctrlRd), 0);
    pushByte(8'hA5);
    chk("R8", 32'(dataReady), 1);
    chk("R8", 32'(statusWord[7:0]), 0);
    doRead();
    chk("R8", 32'(dataReady), 0);
    doRead();
    chk("R8", 32'(statusWord[9]), 0);
    chk("R8", 32'(errWord), 0);
    pushByte(8'h11);
    pushByte(8'h22);
    chk("R8", 32'(errWord[0]), 1);
    doRead();
    chk("R8", 32'(dataReady), 0);
    chk("R8", 32'(scoreQ.size()), 0);

    tick();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule